// File: doc/BRIEF.md
# Eight-Node Chorded Ring Router Node

This block is one node of an eight-node on-chip network arranged as a ring with chords. Each node has two ring neighbours, one on each side, and a chord to the node directly opposite. The node has four ingress ports: the local processor, the clockwise inbound link, the counter-clockwise inbound link and the chord inbound link. It also has four egress ports: local ejection, clockwise, counter-clockwise and chord. Each packet names a destination node, and the node picks the egress on the shortest path from that name. Through traffic from the three inbound links goes through the same route step as local traffic. Any destination is reached in two hops or fewer.

The route step has no buffering of its own. All storage sits in one queue per egress. Several ingress ports may want the same queue in one cycle. The queue then takes the request that has waited longest, and a tie goes to the lower ingress index. The other requesters are held but not blocked, so a port whose queue has room still proceeds. A queue that reaches its stop level refuses new entries. The requester waits with its packet held, so no packet is ever dropped.

Top module: `ring_node_router`

## Requirements
- R1: After reset, every egress queue is empty, so `out_valid` is 0 on all four egress ports.
- R2: With rel = (destination − SELF_ID) mod 8, the egress port is chosen as follows: rel 0 goes to ejection (port 0), rel 1 or 2 goes clockwise (port 1), rel 6 or 7 goes counter-clockwise (port 2), and rel 3, 4 or 5 goes to the chord (port 3). This applies to all ingress ports.
- R3: The packet layout is {destination[3], source[3], data[DATA_W]}, with the destination in the top bits. A packet accepted at a clock edge is shown unchanged on its egress port right after that edge.
- R4: Each egress queue delivers its packets in the order it accepted them.
- R5: When several ingress ports request the same egress queue, the queue grants the one whose request became valid earliest.
- R6: When competing requests became valid in the same cycle, the lower ingress index is granted.
- R7: An egress queue that holds STOP_LVL entries accepts nothing, and the requester sees `in_ready` low with its packet held. The packet is accepted once the queue drains, so no packet is lost.
- R8: While `out_valid` is high and `out_ready` is low, the egress port keeps `out_valid` high and `out_pkt` stable.
- R9: Requests aimed at different egress queues are all accepted in the same cycle. A stalled request does not hold up other ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Request valid, one bit per ingress port (0 local, 1 clockwise in, 2 counter-clockwise in, 3 chord in) |
| in_ready | output | 4 | Request accepted this cycle, one bit per ingress port |
| in_pkt | input | 4*(6+DATA_W) | Ingress packets, port i in slice i |
| out_valid | output | 4 | Egress queue not empty (0 eject, 1 clockwise, 2 counter-clockwise, 3 chord) |
| out_ready | input | 4 | Downstream takes the egress head packet |
| out_pkt | output | 4*(6+DATA_W) | Egress head packets, port e in slice e |

## Verification
`in_ready` is a combinational function of the current requests and the queue levels. The bench therefore reads it a short delay after driving the inputs on the falling edge, and before the rising edge that performs the transfer. Whether a packet was accepted, and where it went, shows one rising edge later on `out_valid` and `out_pkt`, and the bench samples those on the next falling edge. A pop takes effect on the rising edge where `out_ready` is high. A queue that was at its stop level grants again only on the edge after that pop. The bench therefore checks the arbitration winner on the falling edge between those two rising edges.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  localparam int NODE_W  = 3;
  localparam int N_PORTS = 4;

  typedef enum logic [1:0] {
    PORT_EJECT = 2'd0,
    PORT_CW    = 2'd1,
    PORT_CCW   = 2'd2,
    PORT_CHORD = 2'd3
  } port_e;

  // Shortest-path egress choice from the destination's offset around the ring.
  function automatic port_e pick_egress(input logic [NODE_W-1:0] self_id,
                                        input logic [NODE_W-1:0] dest);
    logic [NODE_W-1:0] rel;
    rel = dest - self_id;
    case (rel)
      3'd0:       return PORT_EJECT;
      3'd1, 3'd2: return PORT_CW;
      3'd6, 3'd7: return PORT_CCW;
      default:    return PORT_CHORD;
    endcase
  endfunction
endpackage

// File: rtl/rn_arrival.sv
module rn_arrival #(
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid,
  input  logic            ready,
  input  logic [TS_W-1:0] now,
  output logic [TS_W-1:0] age
);
  logic            waiting_q;
  logic [TS_W-1:0] stamp_q;
  logic [TS_W-1:0] stamp_eff;

  assign stamp_eff = waiting_q ? stamp_q : now;
  assign age       = now - stamp_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting_q <= 1'b0;
      stamp_q   <= '0;
    end else if (valid && !ready) begin
      waiting_q <= 1'b1;
      stamp_q   <= stamp_eff;
    end else begin
      waiting_q <= 1'b0;
    end
  end

  // R5
  waiting_age_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (!valid || age != '0));
endmodule

// File: rtl/rn_oldest_arb.sv
module rn_oldest_arb #(
  parameter int N    = 4,
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [N-1:0]    req,
  input  logic [N*TS_W-1:0] ages,
  output logic [N-1:0]    gnt
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic            found;
  logic [IDX_W-1:0] best;
  logic [TS_W-1:0] best_age;

  always_comb begin
    found    = 1'b0;
    best     = '0;
    best_age = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || ages[i*TS_W +: TS_W] > best_age)) begin
        found    = 1'b1;
        best     = IDX_W'(i);
        best_age = ages[i*TS_W +: TS_W];
      end
    end
    gnt = '0;
    if (en && found) gnt[best] = 1'b1;
  end

  // R5
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~req) == '0));

  genvar gi, gj;
  generate
    for (gi = 0; gi < N; gi++) begin : g_w
      for (gj = 0; gj < N; gj++) begin : g_l
        // R5
        oldest_first_chk: assert property (@(posedge clk) disable iff (rst)
          (gnt[gi] && req[gj]) |-> (ages[gj*TS_W +: TS_W] <= ages[gi*TS_W +: TS_W]));
      end
    end
  endgenerate
endmodule

// File: rtl/rn_egress_q.sv
module rn_egress_q #(
  parameter int W        = 22,
  parameter int DEPTH    = 4,
  parameter int STOP_LVL = DEPTH - 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         stop,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             rd_en;

  assign stop      = count >= CNT_W'(STOP_LVL);
  assign out_valid = count != '0;
  assign out_data  = mem[rd_ptr];
  assign rd_en     = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(wr_en) - CNT_W'(rd_en);
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(STOP_LVL));
  // R7
  no_write_at_stop_chk: assert property (@(posedge clk) disable iff (rst)
    stop |-> !wr_en);
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/ring_node_router.sv
module ring_node_router
  import ring_node_pkg::*;
#(
  parameter int SELF_ID  = 0,
  parameter int DATA_W   = 16,
  parameter int Q_DEPTH  = 4,
  parameter int STOP_LVL = Q_DEPTH - 1,
  parameter int TS_W     = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_PORTS-1:0]             in_valid,
  output logic [N_PORTS-1:0]             in_ready,
  input  logic [N_PORTS*(6+DATA_W)-1:0]  in_pkt,
  output logic [N_PORTS-1:0]             out_valid,
  input  logic [N_PORTS-1:0]             out_ready,
  output logic [N_PORTS*(6+DATA_W)-1:0]  out_pkt
);
  localparam int PKT_W = 2*NODE_W + DATA_W;
  localparam logic [NODE_W-1:0] SELF = NODE_W'(SELF_ID);

  logic [TS_W-1:0]         ts_now;
  port_e                   tgt  [N_PORTS];
  logic [N_PORTS*TS_W-1:0] ages;
  logic [N_PORTS-1:0]      gnt  [N_PORTS];

  always_ff @(posedge clk) begin
    if (rst) ts_now <= '0;
    else     ts_now <= ts_now + 1'b1;
  end

  genvar i, e;
  generate
    for (i = 0; i < N_PORTS; i++) begin : g_in
      assign tgt[i] = pick_egress(SELF, in_pkt[i*PKT_W + PKT_W - 1 -: NODE_W]);
      rn_arrival #(.TS_W(TS_W)) arrival_i (
        .clk(clk), .rst(rst),
        .valid(in_valid[i]), .ready(in_ready[i]),
        .now(ts_now), .age(ages[i*TS_W +: TS_W])
      );
    end

    for (e = 0; e < N_PORTS; e++) begin : g_out
      logic [N_PORTS-1:0] req;
      logic               stop;
      logic [PKT_W-1:0]   wdata;

      always_comb begin
        wdata = '0;
        for (int k = 0; k < N_PORTS; k++) begin
          req[k] = in_valid[k] && (tgt[k] == port_e'(e));
          if (gnt[e][k]) wdata = wdata | in_pkt[k*PKT_W +: PKT_W];
        end
      end

      rn_oldest_arb #(.N(N_PORTS), .TS_W(TS_W)) arb_i (
        .clk(clk), .rst(rst), .en(!stop),
        .req(req), .ages(ages), .gnt(gnt[e])
      );

      rn_egress_q #(.W(PKT_W), .DEPTH(Q_DEPTH), .STOP_LVL(STOP_LVL)) q_i (
        .clk(clk), .rst(rst),
        .wr_en(|gnt[e]), .wr_data(wdata), .stop(stop),
        .out_valid(out_valid[e]), .out_ready(out_ready[e]),
        .out_data(out_pkt[e*PKT_W +: PKT_W])
      );
    end
  endgenerate

  always_comb begin
    in_ready = '0;
    for (int ee = 0; ee < N_PORTS; ee++) in_ready = in_ready | gnt[ee];
  end

  // R7
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready & ~in_valid) == '0);
endmodule

// File: tb/ring_node_router_tb_top.sv
module ring_node_router_tb_top;
  localparam int SELF   = 2;
  localparam int DATA_W = 16;
  localparam int PKT_W  = 6 + DATA_W;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [3:0]           in_valid = '0;
  logic [3:0]           in_ready;
  logic [4*PKT_W-1:0]   in_pkt = '0;
  logic [3:0]           out_valid;
  logic [3:0]           out_ready = '0;
  logic [4*PKT_W-1:0]   out_pkt;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ring_node_router #(.SELF_ID(SELF), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
    .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt)
  );

  function automatic logic [PKT_W-1:0] mk(input int d, input int s, input int v);
    return {3'(d), 3'(s), 16'(v)};
  endfunction

  function automatic int egress_of(input int d);
    int rel;
    rel = (d - SELF) & 7;
    if (rel == 0) return 0;
    if (rel == 1 || rel == 2) return 1;
    if (rel == 6 || rel == 7) return 2;
    return 3;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input int p, input int d, input int v);
    in_pkt[p*PKT_W +: PKT_W] = mk(d, p, v);
    in_valid[p] = 1'b1;
  endtask

  task automatic push(input int p, input int d, input int v);
    drive(p, d, v);
    #1 chk("R7 push accepted", 64'(in_ready[p]), 64'd1);
    tick();
    in_valid[p] = 1'b0;
  endtask

  task automatic pop_expect(input int e, input logic [PKT_W-1:0] exp, input string tag);
    chk(tag, 64'(out_valid[e]), 64'd1);
    chk(tag, 64'(out_pkt[e*PKT_W +: PKT_W]), 64'(exp));
    out_ready[e] = 1'b1;
    tick();
    out_ready[e] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset out_valid", 64'(out_valid), 64'd0);
  endtask

  task automatic t_route();
    for (int d = 0; d < 8; d++) begin
      drive(0, d, 16'h50 + d);
      tick();
      in_valid[0] = 1'b0;
      chk("R2 egress choice", 64'(out_valid), 64'(4'b1 << egress_of(d)));
      pop_expect(egress_of(d), mk(d, 0, 16'h50 + d), "R3 fields intact");
    end
    // through traffic from the chord link
    drive(3, 7, 16'hA7);
    tick();
    in_valid[3] = 1'b0;
    chk("R2 through route", 64'(out_valid), 64'(4'b1 << egress_of(7)));
    pop_expect(egress_of(7), mk(7, 3, 16'hA7), "R3 through fields");
  endtask

  task automatic t_stop();
    push(0, 3, 16'h11);
    push(0, 4, 16'h12);
    push(0, 3, 16'h13);
    drive(0, 4, 16'h14);
    for (int c = 0; c < 3; c++) begin
      #1 chk("R7 refused at stop level", 64'(in_ready[0]), 64'd0);
      chk("R8 head held", 64'(out_pkt[PKT_W +: PKT_W]), 64'(mk(3, 0, 16'h11)));
      tick();
    end
    pop_expect(1, mk(3, 0, 16'h11), "R4 order 1");
    #1 chk("R7 accepted after drain", 64'(in_ready[0]), 64'd1);
    tick();
    in_valid[0] = 1'b0;
    pop_expect(1, mk(4, 0, 16'h12), "R4 order 2");
    pop_expect(1, mk(3, 0, 16'h13), "R4 order 3");
    pop_expect(1, mk(4, 0, 16'h14), "R7 no loss");
    chk("R7 queue empty", 64'(out_valid), 64'd0);
  endtask

  task automatic t_oldest();
    push(0, 3, 16'h21);
    push(0, 3, 16'h22);
    push(0, 3, 16'h23);
    drive(3, 4, 16'hA0);
    tick();
    drive(1, 3, 16'hB0);
    tick();
    tick();
    drive(0, 4, 16'hC0);
    tick();
    #1 chk("R7 all held", 64'(in_ready), 64'd0);
    pop_expect(1, mk(3, 0, 16'h21), "R4 filler 1");
    #1 chk("R5 oldest chord port", 64'(in_ready), 64'b1000);
    tick();
    in_valid[3] = 1'b0;
    pop_expect(1, mk(3, 0, 16'h22), "R4 filler 2");
    #1 chk("R5 next oldest cw port", 64'(in_ready), 64'b0010);
    tick();
    in_valid[1] = 1'b0;
    pop_expect(1, mk(3, 0, 16'h23), "R4 filler 3");
    #1 chk("R5 youngest local", 64'(in_ready), 64'b0001);
    tick();
    in_valid[0] = 1'b0;
    pop_expect(1, mk(4, 3, 16'hA0), "R4 winner 1");
    pop_expect(1, mk(3, 1, 16'hB0), "R4 winner 2");
    pop_expect(1, mk(4, 0, 16'hC0), "R4 winner 3");
  endtask

  task automatic t_tie();
    drive(1, 1, 16'h61);
    drive(2, 0, 16'h62);
    #1 chk("R6 tie lower index", 64'(in_ready), 64'b0010);
    tick();
    in_valid[1] = 1'b0;
    #1 chk("R6 loser next", 64'(in_ready), 64'b0100);
    tick();
    in_valid[2] = 1'b0;
    pop_expect(2, mk(1, 1, 16'h61), "R6 order 1");
    pop_expect(2, mk(0, 2, 16'h62), "R6 order 2");
  endtask

  task automatic t_parallel();
    drive(0, 3, 16'h71);
    drive(1, 2, 16'h72);
    drive(2, 1, 16'h73);
    drive(3, 6, 16'h74);
    #1 chk("R9 all accepted", 64'(in_ready), 64'hF);
    tick();
    in_valid = '0;
    chk("R9 all egress valid", 64'(out_valid), 64'hF);
    pop_expect(0, mk(2, 1, 16'h72), "R9 eject");
    pop_expect(1, mk(3, 0, 16'h71), "R9 cw");
    pop_expect(2, mk(1, 2, 16'h73), "R9 ccw");
    pop_expect(3, mk(6, 3, 16'h74), "R9 chord");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_route();
    t_stop();
    t_oldest();
    t_tie();
    t_parallel();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule